// File: doc/BRIEF.md
# Two-Pattern Delay Test Scan Controller

This block is a muxed-D scan chain of parameterised length with a small sequencer that applies two-pattern delay tests to a combinational circuit under test. Each chain cell picks either its functional input from the logic under test or the output of the cell before it. A shared scan enable makes that choice. The chain's parallel contents drive the logic under test, and the logic's response comes back on the functional inputs.

A start strobe begins one complete test. The sequencer shifts the first vector in serially. It then launches the second vector with the method chosen at start. In broadside mode the second vector is the logic's response to the first vector, taken with one functional clock. In skewed-load mode the second vector is the first vector moved along the chain by one more shift. One capture clock then stores the response to the second vector. The sequencer shifts that response out while the following vector shifts in.

Serial scan data and the parallel vectors are bit-level test signals that move every cycle under control of the sequencer. They therefore have no valid/ready handshake. The caller must present a new scan-in bit on every shift cycle and take scan-out on the same cycle. All control and status pins are plain levels or single-cycle pulses.

Top module: `delay_scan_ctrl`

## Requirements
- R1: After reset the controller is idle: scan_en, busy and done are low, and every chain cell (state_out) and scan_out are 0.
- R2: A start in idle begins a load phase of exactly N cycles with scan_en high. On each shift, cell 0 takes scan_in and cell i takes cell i-1. The bit driven in the first load cycle therefore ends in cell N-1 (the MSB of state_out).
- R3: In broadside mode (mode=0 at start), the cycle after the load is a launch cycle with scan_en low. During that cycle every cell loads its bit of func_in.
- R4: In skewed-load mode (mode=1 at start), the launch cycle has scan_en high and shifts the chain one more place. Cell 0 takes the scan_in value of that cycle.
- R5: The cycle after launch is a capture cycle with scan_en low. During that cycle every cell loads its bit of func_in.
- R6: done is high for exactly one cycle, the cycle that follows the capture edge.
- R7: After capture comes an unload phase of N cycles with scan_en high. In each cycle scan_out shows cell N-1 before the shift, so the captured response leaves MSB first. At the end of the phase the chain holds the N bits shifted in during the unload.
- R8: busy rises in the cycle after the accepted start and stays high for exactly 2N+2 cycles. scan_en is never high while busy is low.
- R9: A start that arrives while busy has no effect. The test in progress keeps its timing, and no new test begins after it ends.
- R10: While idle the chain holds its contents whatever func_in and scan_in do.
- R11: The launch method is taken from mode at the accepted start. Later changes of mode during the test have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Single-cycle request to run one two-pattern test |
| mode | input | 1 | Launch method: 0 broadside, 1 skewed-load (sampled at start) |
| scan_in | input | 1 | Serial test data into cell 0 |
| func_in | input | N | Response of the logic under test, bit i to cell i |
| scan_out | output | 1 | Serial data from cell N-1 |
| state_out | output | N | Chain contents applied to the logic under test |
| scan_en | output | 1 | High selects the shift path, low selects functional load |
| busy | output | 1 | High while a test is in progress |
| done | output | 1 | One-cycle pulse after the capture cycle |

## Verification
Assertions check on every cycle the following properties:
- each cell's update rule (shift, parallel load, or hold);
- the launch-to-capture ordering and the single-cycle shape of done;
- the shift-counter range and wrap;
- that mode stays fixed and scan_en stays inside busy during a test;
- that a repeated start during a test does not drop busy.

Only the bench's scenarios can show the following:
- that the N-cycle phases line up end to end;
- that the vector shifted in lands with the right bit order;
- that each launch method yields the expected second vector for every first vector;
- that the unloaded stream matches the response computed for the second vector.

The bench sweeps all first vectors of a 4-cell chain. It covers both modes and both values of the skew bit, and it flips mode and pulses start during each run.

// File: rtl/dly_scan_pkg.sv
package dly_scan_pkg;
  typedef enum logic [2:0] {
    PH_IDLE    = 3'd0,
    PH_LOAD    = 3'd1,
    PH_LAUNCH  = 3'd2,
    PH_CAPTURE = 3'd3,
    PH_UNLOAD  = 3'd4
  } phase_e;
endpackage

// File: rtl/dly_scan_chain.sv
module dly_scan_chain #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         se,
  input  logic         si,
  input  logic [N-1:0] d,
  output logic [N-1:0] q,
  output logic         so
);
  logic [N-1:0] prev;

  // Scan path: cell 0 fed from the serial input, every other cell from its neighbour.
  generate
    for (genvar i = 0; i < N; i++) begin : g_cell
      if (i == 0) begin : g_head
        assign prev[i] = si;
      end else begin : g_body
        assign prev[i] = q[i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (en) q <= se ? prev : d;
  end

  assign so = q[N-1];

  p_shift_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && se) |=> (q[N-1:1] == $past(q[N-2:0]) && q[0] == $past(si)));
  p_parallel_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !se) |=> (q == $past(d)));
  p_hold_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(q));
endmodule

// File: rtl/dly_bit_counter.sv
module dly_bit_counter #(
  parameter int N = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic inc,
  output logic last
);
  localparam int CW = (N > 2) ? $clog2(N) : 1;
  localparam logic [CW-1:0] TOP = CW'(N - 1);

  logic [CW-1:0] cnt;

  assign last = (cnt == TOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (inc) cnt <= last ? '0 : cnt + CW'(1);
  end

  p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= TOP);
  p_cnt_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && last) |=> (cnt == '0));
endmodule

// File: rtl/dly_seq_fsm.sv
module dly_seq_fsm
  import dly_scan_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic mode,
  input  logic last,
  output logic scan_en,
  output logic chain_en,
  output logic cnt_inc,
  output logic busy,
  output logic done
);
  phase_e phase, phase_nx;
  logic   mode_q;

  always_comb begin
    phase_nx = phase;
    unique case (phase)
      PH_IDLE:    if (start) phase_nx = PH_LOAD;
      PH_LOAD:    if (last)  phase_nx = PH_LAUNCH;
      PH_LAUNCH:             phase_nx = PH_CAPTURE;
      PH_CAPTURE:            phase_nx = PH_UNLOAD;
      PH_UNLOAD:  if (last)  phase_nx = PH_IDLE;
      default:               phase_nx = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_IDLE;
      mode_q <= 1'b0;
      done   <= 1'b0;
    end else begin
      phase <= phase_nx;
      done  <= (phase == PH_CAPTURE);
      if (phase == PH_IDLE && start) mode_q <= mode;
    end
  end

  assign busy     = (phase != PH_IDLE);
  assign chain_en = busy;
  assign cnt_inc  = (phase == PH_LOAD) || (phase == PH_UNLOAD);
  assign scan_en  = cnt_inc || (phase == PH_LAUNCH && mode_q);

  p_launch_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_LAUNCH) |=> (phase == PH_CAPTURE && !scan_en));
  p_done_after_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_CAPTURE) |=> done);
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_se_in_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    scan_en |-> busy);
  p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !(phase == PH_UNLOAD && last)) |=> busy);
  p_mode_held_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(mode_q));
endmodule

// File: rtl/delay_scan_ctrl.sv
module delay_scan_ctrl #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         mode,
  input  logic         scan_in,
  input  logic [N-1:0] func_in,
  output logic         scan_out,
  output logic [N-1:0] state_out,
  output logic         scan_en,
  output logic         busy,
  output logic         done
);
  logic chain_en;
  logic cnt_inc;
  logic cnt_last;

  dly_seq_fsm u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .mode     (mode),
    .last     (cnt_last),
    .scan_en  (scan_en),
    .chain_en (chain_en),
    .cnt_inc  (cnt_inc),
    .busy     (busy),
    .done     (done)
  );

  dly_bit_counter #(.N(N)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (cnt_inc),
    .last  (cnt_last)
  );

  dly_scan_chain #(.N(N)) u_chain (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (chain_en),
    .se    (scan_en),
    .si    (scan_in),
    .d     (func_in),
    .q     (state_out),
    .so    (scan_out)
  );
endmodule

// File: tb/delay_scan_ctrl_test.sv
module delay_scan_ctrl_test;
  localparam int N = 4;
  localparam time CLK_PERIOD = 10ns;
  localparam logic [N-1:0] CUT_MASK = 4'b0110;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic         mode = 1'b0;
  logic         scan_in = 1'b0;
  logic [N-1:0] func_in;
  logic         scan_out;
  logic [N-1:0] state_out;
  logic         scan_en;
  logic         busy;
  logic         done;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // Model of the logic under test: rotate left by one, then invert selected bits.
  function automatic logic [N-1:0] cut(input logic [N-1:0] v);
    return ((v << 1) | (v >> (N-1))) ^ CUT_MASK;
  endfunction

  assign func_in = cut(state_out);

  delay_scan_ctrl #(.N(N)) uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .mode      (mode),
    .scan_in   (scan_in),
    .func_in   (func_in),
    .scan_out  (scan_out),
    .state_out (state_out),
    .scan_en   (scan_en),
    .busy      (busy),
    .done      (done)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic run_test(input logic [N-1:0] p, input logic m, input logic lb, input logic [N-1:0] q);
    logic [N-1:0] v2;
    logic [N-1:0] r;
    @(negedge clk);
    start = 1'b1;
    mode  = m;
    for (int k = 0; k < N; k++) begin
      @(negedge clk);
      start = 1'b0;
      mode  = ~m;                        // R11: later mode changes must not matter
      chk(scan_en == 1'b1 && busy == 1'b1, "R2", {scan_en, busy}, 2'b11);
      scan_in = p[N-1-k];
    end
    @(negedge clk);                      // launch cycle
    chk(state_out == p, "R2", state_out, p);
    chk(scan_en == m, m ? "R4" : "R3", scan_en, m);
    scan_in = lb;
    start   = 1'b1;                      // R9: start while busy
    @(negedge clk);                      // capture cycle
    start = 1'b0;
    v2 = m ? {p[N-2:0], lb} : cut(p);
    chk(state_out == v2, m ? "R4" : "R3", state_out, v2);
    chk(scan_en == 1'b0 && done == 1'b0, "R5", {scan_en, done}, 2'b00);
    r = cut(v2);
    @(negedge clk);                      // first unload cycle
    chk(done == 1'b1, "R6", done, 1);
    chk(state_out == r, "R5", state_out, r);
    for (int k = 0; k < N; k++) begin
      chk(scan_out == r[N-1-k], "R7", scan_out, r[N-1-k]);
      chk(scan_en == 1'b1 && busy == 1'b1, "R8", {scan_en, busy}, 2'b11);
      if (k > 0) chk(done == 1'b0, "R6", done, 0);
      scan_in = q[N-1-k];
      @(negedge clk);
    end
    chk(busy == 1'b0 && scan_en == 1'b0, "R8", {busy, scan_en}, 2'b00);
    chk(state_out == q, "R7", state_out, q);
    scan_in = ~scan_in;
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      chk(state_out == q, "R10", state_out, q);
      chk(busy == 1'b0, "R9", busy, 0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R8: watchdog expired, actual busy %0b expected run to end", busy);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(scan_en == 0 && busy == 0 && done == 0, "R1", {scan_en, busy, done}, 0);
    chk(state_out == '0 && scan_out == 0, "R1", {state_out, scan_out}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int pv = 0; pv < (1 << N); pv++) begin
      for (int mv = 0; mv < 2; mv++) begin
        for (int bv = 0; bv < 2; bv++) begin
          run_test(N'(pv), mv[0], bv[0], ~N'(pv) ^ N'(mv * 5));
        end
      end
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule